// File: doc/BRIEF.md
# Stereo Serial PCM Receiver

This block takes a three-wire serial audio link (bit clock, word-select, data) into the system clock domain and turns it into parallel 16-bit two's-complement samples, one output lane per channel. A pin chooses whether word-select high or word-select low marks the left channel. A second pin selects one of two framings: I2S, with a one-bit delay after each word-select change, or right-justified, where the last bit before the word-select change is the LSB.

Each lane carries a data word and a valid strobe that is high for one clock. There is no ready input and no back-pressure: a consumer must take the word in the strobe cycle, and the word then stays on the data output until the next word of that channel replaces it. The block also drives an active-low flag that goes low while the incoming audio has been silent (all-zero samples) for a programmable number of frames.

The serial lines pass through a synchroniser. Each bit-clock level must therefore last at least two system clocks. The format and polarity pins are meant to be static and should only change while reset is held.

Top module: `pcm_serial_rx`

## Requirements
- R1: With `fmt_i2s`=1, the edge seen on the first bit-clock rise after a word-select change carries no sample bit. The next 16 rises carry the sample, MSB first. The word is presented after the 16th of these rises.
- R2: With `fmt_i2s`=0, a half-frame's last 16 bits before the word-select change form the sample, MSB first, so the LSB comes on the last rise before the change. The word is presented on the rise that sees the change. Any earlier bits in the half-frame are dropped.
- R3: A half-frame is left-channel data when the word-select level equals `ws_left_hi`, and right-channel data otherwise.
- R4: A word's valid strobe rises SYNC_STAGES+1 clocks after the bit-clock rise that completes the word, and stays high for exactly one clock. The data output holds its value until the next strobe of that channel. Left and right strobes are never high together.
- R5: In I2S framing, bit-clock rises after the 16th data bit of a half-frame have no effect on either output lane.
- R6: `zero_n` goes low one clock after the strobe of the sample that completes 2×ZERO_FRAMES consecutive zero-valued samples, counted across both channels. ZERO_FRAMES defaults to 2048.
- R7: `zero_n` returns high one clock after the strobe of the first non-zero sample.
- R8: While `rst_n` is low, both data outputs are zero, both strobes are low and `zero_n` is high. After reset, no word is produced until one bit-clock rise has been seen and a word-select change has followed it.
- R9: The bit clock, word-select and data inputs are sampled only through a SYNC_STAGES-deep synchroniser. Word-select and data are taken at the same point as the bit-clock rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial bit clock |
| ws | input | 1 | Word-select (channel) clock |
| sd | input | 1 | Serial data |
| fmt_i2s | input | 1 | 1: I2S framing, 0: right-justified framing |
| ws_left_hi | input | 1 | Word-select level that marks the left channel |
| left_data | output | SAMPLE_W | Last left-channel sample |
| left_valid | output | 1 | One-clock strobe for a new left sample |
| right_data | output | SAMPLE_W | Last right-channel sample |
| right_valid | output | 1 | One-clock strobe for a new right sample |
| zero_n | output | 1 | Low while the input has been silent long enough |

## Verification
The bench drives each bit-clock rise itself. When a rise completes a word, it queues that word with a due cycle three clocks later: two synchroniser stages plus the output register. On every falling clock edge it compares both strobes and both data outputs with the queue head. The silence flag is due one clock after the strobe that decides it, so the model updates its expected flag only after comparing the current one. For right-justified words, the expectation is queued on the rise that changes word-select, not on the LSB rise.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;

  function automatic chan_e ws_to_chan(input logic ws_lvl, input logic left_hi);
    return (ws_lvl == left_hi) ? CH_LEFT : CH_RIGHT;
  endfunction
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic ws,
  input  logic sd,
  output logic rise,
  output logic ws_s,
  output logic sd_s
);
  localparam int LANES = 3;

  logic [STAGES-1:0][LANES-1:0] chain;
  logic                         sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain    <= '0;
      sck_prev <= 1'b0;
    end else begin
      chain[0] <= {sck, ws, sd};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      sck_prev <= chain[STAGES-1][2];
    end
  end

  assign rise = chain[STAGES-1][2] & ~sck_prev;
  assign ws_s = chain[STAGES-1][1];
  assign sd_s = chain[STAGES-1][0];

  // R9: a rise event is a single-cycle pulse
  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pcm_deser.sv
module pcm_deser
  import pcm_rx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ws,
  input  logic         sd,
  input  logic         fmt_i2s,
  input  logic         left_hi,
  output logic [W-1:0] l_data,
  output logic         l_valid,
  output logic [W-1:0] r_data,
  output logic         r_valid
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          seen, armed, ws_prev;
  logic [CW-1:0] cnt;
  chan_e         chan_q;
  logic [W-1:0]  shreg;

  logic          trans, emit;
  chan_e         emit_ch;
  logic [W-1:0]  emit_word;

  assign trans = seen && (ws != ws_prev);

  always_comb begin
    emit      = 1'b0;
    emit_ch   = chan_q;
    emit_word = shreg;
    if (fmt_i2s) begin
      emit      = tick && !trans && (cnt == LAST);
      emit_word = {shreg[W-2:0], sd};
      emit_ch   = chan_q;
    end else begin
      emit      = tick && trans && armed;
      emit_word = shreg;
      emit_ch   = ws_to_chan(ws_prev, left_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      armed   <= 1'b0;
      ws_prev <= 1'b0;
      cnt     <= FULL;
      chan_q  <= CH_LEFT;
      shreg   <= '0;
    end else if (tick) begin
      seen    <= 1'b1;
      ws_prev <= ws;
      if (trans) begin
        armed  <= 1'b1;
        chan_q <= ws_to_chan(ws, left_hi);
        cnt    <= '0;
        if (!fmt_i2s) shreg <= {{(W-1){1'b0}}, sd};
      end else if (fmt_i2s) begin
        if (cnt != FULL) begin
          shreg <= {shreg[W-2:0], sd};
          cnt   <= cnt + 1'b1;
        end
      end else begin
        shreg <= {shreg[W-2:0], sd};
      end
    end
  end

  logic [W-1:0] lane_data  [2];
  logic         lane_valid [2];

  for (genvar c = 0; c < 2; c++) begin : g_lane
    localparam chan_e MY_CH = (c == 0) ? CH_LEFT : CH_RIGHT;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_data[c]  <= '0;
        lane_valid[c] <= 1'b0;
      end else begin
        lane_valid[c] <= emit && (emit_ch == MY_CH);
        if (emit && (emit_ch == MY_CH)) lane_data[c] <= emit_word;
      end
    end
  end

  assign l_data  = lane_data[0];
  assign l_valid = lane_valid[0];
  assign r_data  = lane_data[1];
  assign r_valid = lane_valid[1];

  // R4: strobes last one clock
  a_r4_left_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    l_valid |=> !l_valid);
  a_r4_right_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |=> !r_valid);
  // R4: channels never strobe together
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_valid && r_valid));
  // R4: data held between strobes
  a_r4_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !l_valid |-> $stable(l_data));
  a_r4_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !r_valid |-> $stable(r_data));
endmodule

// File: rtl/pcm_zero_watch.sv
module pcm_zero_watch #(
  parameter int W      = 16,
  parameter int FRAMES = 2048
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         l_valid,
  input  logic [W-1:0] l_data,
  input  logic         r_valid,
  input  logic [W-1:0] r_data,
  output logic         zero_n
);
  localparam int LIMIT = 2 * FRAMES;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic          any_z, any_nz;
  logic [CW-1:0] run, run_nx;

  assign any_z  = (l_valid && (l_data == '0)) || (r_valid && (r_data == '0));
  assign any_nz = (l_valid && (l_data != '0)) || (r_valid && (r_data != '0));

  always_comb begin
    run_nx = run;
    if (any_nz)                   run_nx = '0;
    else if (any_z && run != LIM) run_nx = run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      zero_n <= 1'b1;
    end else begin
      run    <= run_nx;
      zero_n <= (run_nx != LIM);
    end
  end

  // R6: flag only falls after a zero sample strobe
  a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zero_n) |-> $past(any_z));
  // R7: flag only rises after a non-zero sample strobe
  a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_n) |-> $past(any_nz));
  // R8: flag high through reset
  a_r8_reset_flag: assert property (@(posedge clk)
    !rst_n |=> zero_n);
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx #(
  parameter int SAMPLE_W    = 16,
  parameter int ZERO_FRAMES = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                ws,
  input  logic                sd,
  input  logic                fmt_i2s,
  input  logic                ws_left_hi,
  output logic [SAMPLE_W-1:0] left_data,
  output logic                left_valid,
  output logic [SAMPLE_W-1:0] right_data,
  output logic                right_valid,
  output logic                zero_n
);
  logic rise, ws_s, sd_s;

  pcm_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .sck  (sck),
    .ws   (ws),
    .sd   (sd),
    .rise (rise),
    .ws_s (ws_s),
    .sd_s (sd_s)
  );

  pcm_deser #(.W(SAMPLE_W)) u_deser (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (rise),
    .ws     (ws_s),
    .sd     (sd_s),
    .fmt_i2s(fmt_i2s),
    .left_hi(ws_left_hi),
    .l_data (left_data),
    .l_valid(left_valid),
    .r_data (right_data),
    .r_valid(right_valid)
  );

  pcm_zero_watch #(.W(SAMPLE_W), .FRAMES(ZERO_FRAMES)) u_zero (
    .clk    (clk),
    .rst_n  (rst_n),
    .l_valid(left_valid),
    .l_data (left_data),
    .r_valid(right_valid),
    .r_data (right_data),
    .zero_n (zero_n)
  );
endmodule

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;
  localparam int W  = 16;
  localparam int ZF = 4;
  localparam int LIM = 2 * ZF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic fmt_i2s = 1'b1, ws_left_hi = 1'b1;
  logic [W-1:0] left_data, right_data;
  logic left_valid, right_valid, zero_n;

  always #2.5 clk = ~clk;

  pcm_serial_rx #(.SAMPLE_W(W), .ZERO_FRAMES(ZF), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
    .fmt_i2s(fmt_i2s), .ws_left_hi(ws_left_hi),
    .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid), .zero_n(zero_n)
  );

  typedef struct {int due; bit ch; logic [W-1:0] v;} ev_t;
  ev_t q[$];

  int cyc = 0;
  int total = 0, bad = 0;
  bit done = 1'b0;
  string tag = "R8";
  logic [W-1:0] exp_l = '0, exp_r = '0;
  int zrun = 0;
  bit zn_pend = 1'b1;
  bit pend_v = 1'b0, pend_ch = 1'b0;
  logic [W-1:0] pend_val = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    bit elv, erv;
    elv = 1'b0; erv = 1'b0;
    if (q.size() > 0 && q[0].due == cyc) begin
      if (q[0].ch == 1'b0) begin elv = 1'b1; exp_l = q[0].v; end
      else begin erv = 1'b1; exp_r = q[0].v; end
      void'(q.pop_front());
    end
    chk("R4 left strobe", W'(left_valid), W'(elv));
    chk("R4 right strobe", W'(right_valid), W'(erv));
    chk({tag, " left data"}, left_data, exp_l);
    chk({tag, " right data"}, right_data, exp_r);
    chk("R6 R7 zero flag", W'(zero_n), W'(zn_pend));
    if (elv || erv) begin
      if ((elv ? exp_l : exp_r) != '0) zrun = 0;
      else if (zrun < LIM) zrun++;
      zn_pend = (zrun < LIM);
    end
  end

  // one bit-clock period: 2 clocks low, 2 clocks high
  task automatic bit_edge(input logic w, input logic d, input bit push,
                          input bit ch, input logic [W-1:0] val);
    @(negedge clk); #1; sck = 1'b0; ws = w; sd = d;
    @(negedge clk); @(negedge clk); #1; sck = 1'b1;
    // R9: two sync stages plus output register -> due three clocks later
    if (push) q.push_back('{cyc + 3, ch, val});
    @(negedge clk);
  endtask

  function automatic bit ch_of(input logic w);
    return (w == ws_left_hi) ? 1'b0 : 1'b1;
  endfunction

  task automatic i2s_half(input logic w, input logic [W-1:0] val, input int extra);
    bit_edge(w, 1'($urandom), 0, 0, '0);
    for (int i = W - 1; i >= 0; i--) bit_edge(w, val[i], i == 0, ch_of(w), val);
    for (int e = 0; e < extra; e++) bit_edge(w, 1'($urandom), 0, 0, '0);
  endtask

  task automatic rj_half(input logic w, input logic [W-1:0] val, input int lead);
    for (int k = 0; k < lead + W; k++) begin
      logic b;
      b = (k < lead) ? 1'($urandom) : val[W - 1 - (k - lead)];
      bit_edge(w, b, (k == 0) && pend_v, pend_ch, pend_val);
    end
    pend_v = 1'b1; pend_ch = ch_of(w); pend_val = val;
  endtask

  task automatic rj_close(input logic w);
    bit_edge(w, 1'b0, pend_v, pend_ch, pend_val);
    pend_v = 1'b0;
  endtask

  task automatic do_reset(input logic f, input logic p);
    @(negedge clk); #1;
    rst_n = 1'b0; sck = 1'b0; fmt_i2s = f; ws_left_hi = p;
    q.delete(); exp_l = '0; exp_r = '0; zrun = 0; zn_pend = 1'b1; pend_v = 1'b0;
    tag = "R8";
    repeat (3) @(negedge clk);
    #1; rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    // R8: reset state, then I2S with left = ws high
    do_reset(1'b1, 1'b1);
    tag = "R1";
    bit_edge(1'b0, 1'b1, 0, 0, '0);
    i2s_half(1'b1, 16'hA5C3, 0);
    i2s_half(1'b0, 16'h1234, 0);
    tag = "R5";
    i2s_half(1'b1, 16'h8000, 3);
    i2s_half(1'b0, 16'h7FFF, 5);
    tag = "R1";
    i2s_half(1'b1, 16'hFFFF, 0);
    i2s_half(1'b0, 16'h0001, 1);
    settle();

    // R3: I2S with left = ws low
    do_reset(1'b1, 1'b0);
    tag = "R3";
    bit_edge(1'b1, 1'b0, 0, 0, '0);
    i2s_half(1'b0, 16'hC0DE, 0);
    i2s_half(1'b1, 16'h5A5A, 2);
    i2s_half(1'b0, 16'h0F0F, 0);
    i2s_half(1'b1, 16'hBEEF, 0);
    settle();

    // R2: right-justified with left = ws high
    do_reset(1'b0, 1'b1);
    tag = "R2";
    bit_edge(1'b0, 1'b1, 0, 0, '0);
    rj_half(1'b1, 16'h1357, 0);
    rj_half(1'b0, 16'h9BDF, 2);
    rj_half(1'b1, 16'h8001, 5);
    rj_half(1'b0, 16'h7FFE, 0);
    rj_close(1'b1);
    settle();

    // R3: right-justified with left = ws low
    do_reset(1'b0, 1'b0);
    tag = "R3";
    bit_edge(1'b0, 1'b0, 0, 0, '0);
    rj_half(1'b1, 16'h2468, 1);
    rj_half(1'b0, 16'hACE0, 0);
    rj_half(1'b1, 16'hFFFE, 3);
    rj_close(1'b0);
    settle();

    // R6 / R7: silence detection in I2S
    do_reset(1'b1, 1'b1);
    tag = "R6";
    bit_edge(1'b0, 1'b0, 0, 0, '0);
    for (int f = 0; f < ZF + 1; f++) begin
      i2s_half(1'b1, '0, 0);
      i2s_half(1'b0, '0, 0);
    end
    tag = "R7";
    i2s_half(1'b1, 16'h0004, 0);
    i2s_half(1'b0, '0, 0);
    tag = "R6";
    for (int f = 0; f < ZF; f++) begin
      i2s_half(1'b1, '0, 0);
      i2s_half(1'b0, '0, 0);
    end
    settle();
    // R8: reset while flag is low forces it high
    do_reset(1'b1, 1'b1);
    settle();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule